// File: doc/BRIEF.md
# Selective TLB Invalidation Sequencer

This block holds a translation entry array as registers and runs invalidation commands over it. The array has two regions. The first is a set-associative region, in which every entry shares one page size supplied from outside. The second is a fully associative region, in which every entry keeps its own page size. Each entry holds an exists flag, a global flag, a 10-bit address-space identifier, and a virtual page-pair number made of virtual address bits 13 and above.

A command carries an operation code, a global-flag value, an info word whose low 10 bits are the address-space identifier, and a virtual address. Once accepted, the block visits one entry per clock, from index 0 to the last index, and clears the exists flag of each entry the operation selects. A one-cycle done pulse marks the end of the scan. A small write port fills entries while the block is idle. The exists flags are visible on an output vector.

Top module: `tlb_inval_engine`

## Requirements
- R1: After reset every exists bit is 0, `busy` is 0 and `done` is 0.
- R2: While idle, `wr_en` stores global flag, identifier, page-pair number and (for indices 64..79 only) page size into entry `wr_idx` and sets its exists bit on the next edge. A write while `busy` is 1 has no effect.
- R3: A `cmd_start` sampled while idle raises `busy` on the next edge. Entry k is processed on the (k+1)-th edge after that. `done` is high for exactly one cycle, after the edge that processes entry 79, and `busy` is 0 in that same cycle.
- R4: `cmd_start` while `busy` is 1 is ignored and does not change the running operation.
- R5: Operation code 0 clears every entry.
- R6: Operation code 1 clears only entries whose global flag equals `cmd_g`.
- R7: Operation code 2 clears only entries that are non-global and whose identifier equals `cmd_info[9:0]`. Bits of `cmd_info` above bit 9 are ignored.
- R8: Operation code 3 clears entries that are non-global, have a matching identifier and match the page.
- R9: Operation code 4 clears entries that match the page and are either global or have a matching identifier.
- R10: An entry matches the page when (vaddr >> (ps+1)) equals (page-pair number >> (ps+1-13)), for page sizes ps from 12 to 46.
- R11: Entries 0..63 (8 ways of 8 sets) use `shared_ps`. Entries 64..79 use the page size stored with them.
- R12: Operation codes 5, 6 and 7 clear nothing, but they still run the full scan and pulse `done`.
- R13: Exists bits are never set while a scan runs, and they do not change while the block is idle and no write is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command request |
| cmd_op | input | 3 | Operation code |
| cmd_g | input | 1 | Global-flag value for operation 1 |
| cmd_info | input | 32 | Info word; bits 9:0 are the identifier |
| cmd_vaddr | input | 48 | Virtual address for page operations |
| shared_ps | input | 6 | Page size of the set-associative region |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 7 | Entry index to write |
| wr_g | input | 1 | Global flag to store |
| wr_asid | input | 10 | Identifier to store |
| wr_vppn | input | 35 | Page-pair number (address bits 47:13) |
| wr_ps | input | 6 | Page size to store (fully associative entries) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| exists | output | 80 | Exists flag of every entry |

## Verification
The hardest case to reach is one where the page size alone decides the outcome. Entries are placed so that their addresses differ from the command address only in bits that one page size masks and another does not. The same set-associative entries are then invalidated under two values of `shared_ps`, and fully associative entries with page sizes of 12, 14 and 21 sit beside them. A second start pulse and an entry write are driven in the middle of running scans, so that their absence of effect shows up in the final exists vector.

// File: rtl/tlb_inval_pkg.sv
package tlb_inval_pkg;
  localparam int VA_W     = 48;
  localparam int PG_LSB   = 13;
  localparam int VPPN_W   = VA_W - PG_LSB;
  localparam int ASID_W   = 10;
  localparam int PS_W     = 6;
  localparam int OP_W     = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ALL        = 3'd0,
    OP_BY_G       = 3'd1,
    OP_ASID       = 3'd2,
    OP_PAGE_ASID  = 3'd3,
    OP_PAGE_ASIDG = 3'd4
  } inv_op_e;

  typedef struct packed {
    logic              g;
    logic [ASID_W-1:0] asid;
    logic [VPPN_W-1:0] vppn;
  } ent_t;

  typedef struct packed {
    inv_op_e           op;
    logic              g;
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   vaddr;
  } cmd_t;
endpackage

// File: rtl/tlb_inval_match.sv
module tlb_inval_match
  import tlb_inval_pkg::*;
(
  input  ent_t             ent,
  input  logic [PS_W-1:0]  eff_ps,
  input  cmd_t             cmd,
  output logic             hit
);
  logic [VA_W-1:0] low_mask;
  logic [VA_W-1:0] ent_va;
  logic            page_hit;
  logic            asid_hit;

  always_comb begin
    low_mask = (VA_W'(1) << ({1'b0, eff_ps} + 7'd1)) - VA_W'(1);
    ent_va   = {ent.vppn, {PG_LSB{1'b0}}};
    page_hit = ((cmd.vaddr ^ ent_va) & ~low_mask) == '0;
    asid_hit = (ent.asid == cmd.asid);
    case (cmd.op)
      OP_ALL:        hit = 1'b1;
      OP_BY_G:       hit = (ent.g == cmd.g);
      OP_ASID:       hit = !ent.g && asid_hit;
      OP_PAGE_ASID:  hit = !ent.g && asid_hit && page_hit;
      OP_PAGE_ASIDG: hit = (ent.g || asid_hit) && page_hit;
      default:       hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_inval_scan.sv
module tlb_inval_scan #(
  parameter int N     = 80,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [IDX_W-1:0] idx
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    accept = start && !busy_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = '0;
      end
    end else if (idx_q == IDX_W'(N-1)) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign idx  = idx_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R3
  AST_DONE_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !busy_q); // R3
  AST_IDX_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> (idx_q < IDX_W'(N))); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                                   (busy_q && start && idx_q != IDX_W'(N-1)) |=> busy_q); // R4
endmodule

// File: rtl/tlb_inval_engine.sv
module tlb_inval_engine
  import tlb_inval_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int SETS   = 8,
  parameter int FA_N   = 16,
  parameter int INFO_W = 32,
  localparam int SA_N  = WAYS * SETS,
  localparam int N     = SA_N + FA_N,
  localparam int IDX_W = $clog2(N),
  localparam int FA_W  = $clog2(FA_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic              cmd_g,
  input  logic [INFO_W-1:0] cmd_info,
  input  logic [VA_W-1:0]   cmd_vaddr,
  input  logic [PS_W-1:0]   shared_ps,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_g,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPPN_W-1:0] wr_vppn,
  input  logic [PS_W-1:0]   wr_ps,
  output logic              busy,
  output logic              done,
  output logic [N-1:0]      exists
);
  logic             accept;
  logic [IDX_W-1:0] idx;
  cmd_t             cmd_q, cmd_d;
  ent_t             meta_q [N];
  logic [PS_W-1:0]  ps_fa_q [FA_N];
  logic [N-1:0]     exists_q, exists_d;
  logic [N-1:0]     sel_oh;
  logic             wr_ok;
  logic [IDX_W-1:0] wr_off, idx_off;
  logic             idx_fa;
  ent_t             ent_sel;
  logic [PS_W-1:0]  ps_sel;
  logic             hit;

  tlb_inval_scan #(.N(N), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(cmd_start),
    .busy(busy), .done(done), .accept(accept), .idx(idx)
  );

  always_comb begin
    cmd_d       = cmd_q;
    cmd_d.op    = inv_op_e'(cmd_op);
    cmd_d.g     = cmd_g;
    cmd_d.asid  = cmd_info[ASID_W-1:0];
    cmd_d.vaddr = cmd_vaddr;
  end

  always_ff @(posedge clk) begin
    if (accept) cmd_q <= cmd_d;
  end

  assign wr_ok  = wr_en && !busy;
  assign wr_off = wr_idx - IDX_W'(SA_N);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      meta_q[wr_idx] <= '{g: wr_g, asid: wr_asid, vppn: wr_vppn};
    end
    if (wr_ok && wr_idx >= IDX_W'(SA_N)) begin
      ps_fa_q[wr_off[FA_W-1:0]] <= wr_ps;
    end
  end

  always_comb begin
    idx_off = idx - IDX_W'(SA_N);
    idx_fa  = (idx >= IDX_W'(SA_N));
    ent_sel = meta_q[idx];
    ps_sel  = idx_fa ? ps_fa_q[idx_off[FA_W-1:0]] : shared_ps;
    sel_oh  = N'(1) << idx;
  end

  tlb_inval_match u_match (
    .ent(ent_sel), .eff_ps(ps_sel), .cmd(cmd_q), .hit(hit)
  );

  for (genvar i = 0; i < N; i++) begin : g_exists
    logic set_i, clr_i;
    assign set_i       = wr_ok && (wr_idx == IDX_W'(i));
    assign clr_i       = busy && (idx == IDX_W'(i)) && hit;
    assign exists_d[i] = set_i | (exists_q[i] & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exists_q <= '0;
    else        exists_q <= exists_d;
  end

  assign exists = exists_q;

  AST_NO_SET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                                    busy |=> ((exists_q & ~$past(exists_q)) == '0)); // R13
  AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                                    (!busy && !wr_en) |=> $stable(exists_q)); // R13
  AST_ALL_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n)
                                    (busy && cmd_q.op == OP_ALL) |=> ((exists_q & $past(sel_oh)) == '0)); // R5
  AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
                                    (busy && (cmd_q.op == OP_ASID || cmd_q.op == OP_PAGE_ASID)
                                     && ent_sel.g && ((exists_q & sel_oh) != '0))
                                    |=> ((exists_q & $past(sel_oh)) != '0)); // R7
  AST_BAD_OP_NOP:  assert property (@(posedge clk) disable iff (!rst_n)
                                    (busy && cmd_q.op > OP_PAGE_ASIDG) |=> $stable(exists_q)); // R12
endmodule

// File: tb/test_tlb_inval_engine.sv
module test_tlb_inval_engine;
  localparam int N = 80;
  localparam int SA = 64;

  typedef struct {
    logic [N-1:0] vec;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [2:0] cmd_op = '0;
  logic cmd_g = 1'b0;
  logic [31:0] cmd_info = '0;
  logic [47:0] cmd_vaddr = '0;
  logic [5:0] shared_ps = 6'd12;
  logic wr_en = 1'b0;
  logic [6:0] wr_idx = '0;
  logic wr_g = 1'b0;
  logic [9:0] wr_asid = '0;
  logic [34:0] wr_vppn = '0;
  logic [5:0] wr_ps = '0;
  logic busy, done;
  logic [N-1:0] exists;

  int n_chk = 0, n_fail = 0;
  exp_t sb_q[$];

  bit         m_e [N];
  bit         m_g [N];
  bit [9:0]   m_asid [N];
  bit [34:0]  m_vppn [N];
  bit [5:0]   m_ps [N];

  always #5 clk = ~clk;

  tlb_inval_engine i_tlb_inval_engine (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_g(cmd_g),
    .cmd_info(cmd_info), .cmd_vaddr(cmd_vaddr), .shared_ps(shared_ps),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_g(wr_g), .wr_asid(wr_asid),
    .wr_vppn(wr_vppn), .wr_ps(wr_ps), .busy(busy), .done(done), .exists(exists)
  );

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_e[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare at every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) check(1'b0, "R3 unexpected done", N'(1), '0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(exists === e.vec, e.tag, exists, e.vec);
      end
    end
  end

  task automatic wr(input int idx, input bit g, input bit [9:0] asid, input longint unsigned va, input bit [5:0] ps);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 7'(idx); wr_g = g; wr_asid = asid;
    wr_vppn = 35'(va >> 13); wr_ps = ps;
    if (!busy) begin
      m_e[idx] = 1'b1; m_g[idx] = g; m_asid[idx] = asid;
      m_vppn[idx] = 35'(va >> 13); m_ps[idx] = ps;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill();
    wr(0,  0, 5, 64'h1000_0000, 0);
    wr(1,  1, 5, 64'h1000_0000, 0);
    wr(2,  0, 7, 64'h1000_0000, 0);
    wr(3,  0, 5, 64'h2000_0000, 0);
    wr(4,  1, 9, 64'h2000_0000, 0);
    wr(5,  0, 5, 64'h1000_2000, 40);
    wr(64, 0, 5, 64'h1000_0000, 12);
    wr(65, 0, 5, 64'h1020_0000, 21);
    wr(66, 1, 3, 64'h1000_6000, 14);
    wr(67, 0, 5, 64'h1080_0000, 21);
  endtask

  // Independent model of the clear rule, written from R5..R12
  task automatic model_cmd(input int op, input bit g, input bit [31:0] info, input longint unsigned va);
    bit [9:0] a;
    a = info[9:0];
    for (int i = 0; i < N; i++) begin
      int ps;
      bit pg, am, c;
      ps = (i < SA) ? int'(shared_ps) : int'(m_ps[i]);
      pg = ((va & 64'hFFFF_FFFF_FFFF) >> (ps + 1)) == (64'(m_vppn[i]) >> (ps - 12));
      am = (m_asid[i] == a);
      case (op)
        0: c = 1;
        1: c = (m_g[i] == g);
        2: c = !m_g[i] && am;
        3: c = !m_g[i] && am && pg;
        4: c = (m_g[i] || am) && pg;
        default: c = 0;
      endcase
      if (c) m_e[i] = 1'b0;
    end
  endtask

  task automatic launch(input int op, input bit g, input bit [31:0] info, input longint unsigned va, input string tag);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    model_cmd(op, g, info, va);
    e.vec = model_vec(); e.tag = tag;
    sb_q.push_back(e);
    cmd_op = 3'(op); cmd_g = g; cmd_info = info; cmd_vaddr = 48'(va); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || done) @(negedge clk);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_e[i] = 0; m_g[i] = 0; m_asid[i] = 0; m_vppn[i] = 0; m_ps[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(exists === '0 && busy === 1'b0 && done === 1'b0, "R1 reset state", exists, '0);
    rst_n = 1'b1;
    fill();
    @(negedge clk);
    check(exists === model_vec(), "R2 write sets exists", exists, model_vec());

    // R3 timing and R12 illegal op; R2 write during scan ignored
    launch(5, 0, 0, 0, "R12 op5 clears nothing / R2 busy write ignored");
    wr(70, 0, 1, 64'h3000_0000, 12);
    wait_idle();
    check(exists === model_vec(), "R2 entry 70 not written while busy", exists, model_vec());

    @(negedge clk);
    begin
      exp_t e;
      model_cmd(7, 0, 0, 0);
      e.vec = model_vec(); e.tag = "R12 op7 clears nothing";
      sb_q.push_back(e);
    end
    cmd_op = 3'd7; cmd_start = 1'b1;
    @(posedge clk);
    @(negedge clk) cmd_start = 1'b0;
    check(busy === 1'b1, "R3 busy after accept", N'(busy), N'(1));
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b1, "R3 no done before last entry", N'(done), '0);
    @(posedge clk); @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R3 done with busy low", N'({done, busy}), N'(2'b10));
    @(posedge clk); @(negedge clk);
    check(done === 1'b0, "R3 done one cycle", N'(done), '0);

    launch(3, 0, 32'h5, 64'h1000_0000, "R8 R10 R11 page+asid");
    wait_idle(); fill();
    launch(4, 0, 32'h7, 64'h1000_0000, "R9 R10 page+asid-or-g");
    wait_idle(); fill();
    launch(2, 0, 32'h12305, 0, "R7 asid with upper info bits");
    wait_idle(); fill();
    launch(1, 1, 0, 0, "R6 by g=1");
    wait_idle(); fill();
    launch(1, 0, 0, 0, "R6 by g=0");
    wait_idle(); fill();
    shared_ps = 6'd13;
    launch(3, 0, 32'h5, 64'h1000_0000, "R11 shared ps 13");
    wait_idle(); shared_ps = 6'd12; fill();

    // R4: second start during scan ignored
    launch(2, 0, 32'h7, 0, "R4 start while busy ignored");
    repeat (10) @(negedge clk);
    cmd_op = 3'd0; cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
    wait_idle();
    check(busy === 1'b0 && sb_q.size() == 0, "R4 no extra scan", N'(busy), '0);

    launch(0, 0, 0, 0, "R5 clear all");
    wait_idle();
    repeat (5) @(negedge clk);
    check(exists === '0, "R13 idle exists stable", exists, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule